// File: doc/BRIEF.md
# NAND Controller Event Status and Interrupt Unit

This unit gathers the events reported by a NAND flash controller's command sequencer and ECC engine into one 12-bit sticky status register and turns them into a single interrupt line. Each event arrives as a one-cycle pulse and sets its own status bit. The bit then stays set until software writes a one to it. The ready/busy level of the flash is different: it comes in as an asynchronous level, passes through a synchroniser, and only its rising edge sets the ready bit.

A control register holds twelve interrupt-disable bits, one per status bit and in the same positions. A set bit blocks that event from the interrupt line. After reset every event is blocked. Driver software normally writes all ones to the status register before it issues each new command, opens the events it wants to wait for, and clears each event once it has handled it.

Top module: `nfc_irq_status`

## Requirements
- R1: After reset the status register reads 0x000, the control register reads 0xFFF (all interrupts disabled) and `irq` is low.
- R2: Status bit positions: write-command request 0, read-data request 1, write-data request 2, single-bit error 3, double-bit error 4, CS1 bad block 5, CS0 bad block 6, CS1 command done 7, CS0 command done 8, CS1 page done 9, CS0 page done 10, ready 11. A pulse on `evt_pulse[k]` (k = 0..10) sets status bit k at the next clock edge.
- R3: A write to the status address clears every bit written as 1 and leaves bits written as 0 alone. Writing 0xFFF clears the whole register.
- R4: Control bits 11:0 are interrupt disables aligned with the status bits, with 1 meaning disabled. `irq` is high exactly when some status bit is set while its control bit is 0. Control bits above 11 read as 0.
- R5: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set. Other bits cleared by the same write still clear.
- R6: When the double-bit and single-bit error pulses arrive in the same cycle, only bit 4 is set and bit 3 stays clear. A single-bit pulse on its own sets bit 3.
- R7: Bit 11 is set by a low-to-high transition of `rb_level` after synchronisation, SYNC_STAGES+1 clock edges after the input changes. A level that stays high does not set the bit again once it has been cleared, and a falling level sets nothing.
- R8: A status bit stays set after its event pulse has ended until software clears it.
- R9: A write to an address that is neither the control nor the status address changes neither register, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| evt_pulse | input | 11 | Event pulses, bit k sets status bit k |
| rb_level | input | 1 | Asynchronous flash ready level, high = ready |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 32-bit data bus, a 4-bit word address with control at word 0 and status at word 5, a two-stage ready synchroniser and an unregistered interrupt output. With these values the three-edge latency of the ready bit can be checked exactly. Each interrupt change also shows up in the same cycle as the register write or event that causes it, so every mask and clear scenario can be checked with a single sample. Word address 3 is used as the unmapped address for the checks that a write has no effect.

// File: rtl/nfc_stat_pkg.sv
package nfc_stat_pkg;
   localparam int STAT_W      = 12;
   localparam int EVT_W       = STAT_W - 1;
   localparam int BIT_WCMD    = 0;
   localparam int BIT_RDREQ   = 1;
   localparam int BIT_WRREQ   = 2;
   localparam int BIT_SGLERR  = 3;
   localparam int BIT_DBLERR  = 4;
   localparam int BIT_BAD1    = 5;
   localparam int BIT_BAD0    = 6;
   localparam int BIT_CDONE1  = 7;
   localparam int BIT_CDONE0  = 8;
   localparam int BIT_PDONE1  = 9;
   localparam int BIT_PDONE0  = 10;
   localparam int BIT_READY   = 11;
   typedef logic [STAT_W-1:0] stat_vec_t;
   localparam stat_vec_t ALL_DISABLED = '1;
endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nfc_rb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], level_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;

   // R7: a held level produces a single set pulse
   p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/nfc_stat_bank.sv
module nfc_stat_bank #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);
   logic [W-1:0] stat_q;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               stat_q[i] <= 1'b0;
            else if (set_i[i])
               stat_q[i] <= 1'b1;
            else if (clr_i[i])
               stat_q[i] <= 1'b0;
         end
      end
   endgenerate

   assign stat_o = stat_q;

   // R3: a clear with no competing set empties the bit
   p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));
   // R5: a set always lands, even against a clear
   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));
   // R8: bits not cleared stay set
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~clr_i) != '0) |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));
endmodule

// File: rtl/nfc_mask_reg.sv
module nfc_mask_reg #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '1;
      else if (we_i)
         mask_q <= wdata_i;
   end

   assign mask_o = mask_q;

   // R9: no write strobe, no change
   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/nfc_irq_gen.sv
module nfc_irq_gen #(
   parameter int W          = 12,
   parameter bit REGISTERED = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] mask_i,
   output logic         irq_o
);
   logic pending;
   assign pending = |(stat_i & ~mask_i);

   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pending;
         end
         assign irq_o = irq_q;
         // R4: fully disabled masks silence the line one cycle on
         p_all_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_i == '1) |=> !irq_o);
      end else begin : g_comb
         assign irq_o = pending;
         // R4: fully disabled masks silence the line
         p_all_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_i == '1) |-> !irq_o);
         // R4: no pending status, no interrupt
         p_no_stat_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_i == '0) |-> !irq_o);
      end
   endgenerate
endmodule

// File: rtl/nfc_irq_status.sv
module nfc_irq_status
   import nfc_stat_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int CTRL_ADDR   = 0,
   parameter int STAT_ADDR   = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [EVT_W-1:0]  evt_pulse,
   input  logic              rb_level,
   output logic              irq
);
   localparam int PAD_W = DATA_W - STAT_W;
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   generate
      if (DATA_W < 16) begin : g_bad_dw
         $error("nfc_irq_status: DATA_W must be at least 16");
      end
      if (CTRL_ADDR == STAT_ADDR) begin : g_bad_map
         $error("nfc_irq_status: control and status addresses must differ");
      end
      if (CTRL_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("nfc_irq_status: register address outside ADDR_W");
      end
   endgenerate

   logic      hit_ctrl, hit_stat;
   logic      ready_rise;
   stat_vec_t set_vec, clr_vec, stat_q, mask_q;
   logic      unused_hi;

   assign hit_ctrl  = (bus_addr == CTRL_A);
   assign hit_stat  = (bus_addr == STAT_A);
   assign unused_hi = ^bus_wdata[DATA_W-1:STAT_W];

   nfc_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (rb_level),
      .rise_o  (ready_rise)
   );

   // ECC outcome priority: a double-bit report hides a same-cycle single-bit one
   always_comb begin
      set_vec             = {ready_rise, evt_pulse};
      set_vec[BIT_SGLERR] = evt_pulse[BIT_SGLERR] & ~evt_pulse[BIT_DBLERR];
   end

   assign clr_vec = (bus_we && hit_stat) ? bus_wdata[STAT_W-1:0] : '0;

   nfc_stat_bank #(.W(STAT_W)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .stat_o (stat_q)
   );

   nfc_mask_reg #(.W(STAT_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bus_we && hit_ctrl),
      .wdata_i (bus_wdata[STAT_W-1:0]),
      .mask_o  (mask_q)
   );

   nfc_irq_gen #(.W(STAT_W), .REGISTERED(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat_q),
      .mask_i (mask_q),
      .irq_o  (irq)
   );

   always_comb begin
      if (hit_ctrl)      bus_rdata = {{PAD_W{1'b0}}, mask_q};
      else if (hit_stat) bus_rdata = {{PAD_W{1'b0}}, stat_q};
      else               bus_rdata = '0;
   end

   // R6: double-bit wins over single-bit in the same cycle
   p_dbl_over_sgl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse[BIT_DBLERR] && evt_pulse[BIT_SGLERR] && !stat_q[BIT_SGLERR] && !clr_vec[BIT_DBLERR])
      |=> (stat_q[BIT_DBLERR] && !stat_q[BIT_SGLERR]));
   // R2: an event pulse lands in its own bit
   p_evt_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse[BIT_CDONE0] |=> stat_q[BIT_CDONE0]);
endmodule

// File: tb/nfc_irq_status_test.sv
module nfc_irq_status_test;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam logic [AW-1:0] A_CTRL = 4'd0;
   localparam logic [AW-1:0] A_STAT = 4'd5;
   localparam logic [AW-1:0] A_NONE = 4'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [10:0]   evt_pulse = '0;
   logic          rb_level = 1'b0;
   logic          irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   nfc_irq_status uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
      .rb_level(rb_level), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #2 d = bus_rdata;
   endtask

   task automatic pulse(input logic [10:0] v);
      @(negedge clk);
      evt_pulse = v;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      rd(A_CTRL, d); check("R1 ctrl after reset", d, 32'hFFF);
      rd(A_STAT, d); check("R1 status after reset", d, 32'h0);
      check("R1 irq after reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_positions;
      logic [DW-1:0] d;
      for (int b = 0; b < 11; b++) begin
         pulse(11'(1 << b));
         rd(A_STAT, d); check("R2 bit position", d, 32'(1 << b));
         check("R4 masked event no irq", {31'b0, irq}, 32'h0);
         wr(A_STAT, 32'(1 << b));
         rd(A_STAT, d); check("R3 single clear", d, 32'h0);
      end
   endtask

   task automatic t_w1c;
      logic [DW-1:0] d;
      pulse(11'h5A5);
      rd(A_STAT, d); check("R2 multi event", d, 32'h5A5);
      wr(A_STAT, 32'h0A0);
      rd(A_STAT, d); check("R3 partial clear", d, 32'h505);
      wr(A_STAT, 32'h000);
      rd(A_STAT, d); check("R3 zero write no effect", d, 32'h505);
      wr(A_STAT, 32'hFFF);
      rd(A_STAT, d); check("R3 clear all", d, 32'h0);
   endtask

   task automatic t_mask;
      logic [DW-1:0] d;
      wr(A_CTRL, 32'hABCD_0FFB);
      rd(A_CTRL, d); check("R4 ctrl upper bits zero", d, 32'hFFB);
      pulse(11'h002);
      check("R4 disabled bit no irq", {31'b0, irq}, 32'h0);
      pulse(11'h004);
      check("R4 enabled bit irq", {31'b0, irq}, 32'h1);
      wr(A_STAT, 32'h004);
      check("R4 irq drops on clear", {31'b0, irq}, 32'h0);
      wr(A_CTRL, 32'h000);
      check("R4 open mask irq", {31'b0, irq}, 32'h1);
      wr(A_STAT, 32'hFFF);
      check("R4 irq drops on clear all", {31'b0, irq}, 32'h0);
      wr(A_CTRL, 32'hFFF);
   endtask

   task automatic t_set_wins;
      logic [DW-1:0] d;
      pulse(11'h001);
      @(negedge clk);
      bus_addr = A_STAT; bus_wdata = 32'h081; bus_we = 1'b1; evt_pulse = 11'h080;
      @(negedge clk);
      bus_we = 1'b0; evt_pulse = '0;
      rd(A_STAT, d); check("R5 set beats clear", d, 32'h080);
      wr(A_STAT, 32'hFFF);
   endtask

   task automatic t_ecc;
      logic [DW-1:0] d;
      pulse(11'h018);
      rd(A_STAT, d); check("R6 double hides single", d, 32'h010);
      wr(A_STAT, 32'hFFF);
      pulse(11'h008);
      rd(A_STAT, d); check("R6 single alone", d, 32'h008);
      wr(A_STAT, 32'hFFF);
   endtask

   task automatic t_ready;
      logic [DW-1:0] d;
      @(negedge clk);
      rb_level = 1'b1;
      bus_addr = A_STAT;
      @(negedge clk); @(negedge clk);
      #2 check("R7 ready not yet after two edges", bus_rdata, 32'h0);
      @(negedge clk);
      #2 check("R7 ready set on third edge", bus_rdata, 32'h800);
      wr(A_STAT, 32'h800);
      repeat (5) @(negedge clk);
      rd(A_STAT, d); check("R7 held level no re-set", d, 32'h0);
      rb_level = 1'b0;
      repeat (5) @(negedge clk);
      rd(A_STAT, d); check("R7 falling level no set", d, 32'h0);
      rb_level = 1'b1;
      repeat (5) @(negedge clk);
      rd(A_STAT, d); check("R7 second rise sets", d, 32'h800);
      wr(A_STAT, 32'hFFF);
   endtask

   task automatic t_sticky;
      logic [DW-1:0] d;
      pulse(11'h400);
      repeat (10) @(negedge clk);
      rd(A_STAT, d); check("R8 bit stays set", d, 32'h400);
   endtask

   task automatic t_unmapped;
      logic [DW-1:0] d;
      wr(A_NONE, 32'h0000_0FFF);
      rd(A_STAT, d); check("R9 unmapped write keeps status", d, 32'h400);
      wr(A_NONE, 32'h0000_0000);
      rd(A_CTRL, d); check("R9 unmapped write keeps ctrl", d, 32'hFFF);
      rd(A_NONE, d); check("R9 unmapped read zero", d, 32'h0);
      wr(A_STAT, 32'hFFF);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_positions();
      t_w1c();
      t_mask();
      t_set_wins();
      t_ecc();
      t_ready();
      t_sticky();
      t_unmapped();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule